// File: doc/BRIEF.md
# Periodic SYSREF Generator with Local Multiframe Clock

This block runs entirely on the link clock. It produces a SYSREF pulse that repeats at a whole multiple of the local multiframe length, and it keeps the local multiframe counter that the receive path uses to find multiframe boundaries. The multiframe length in link clocks comes from the frames-per-multiframe value K and the octets-per-frame value F. The datapath carries four octets per link clock, so one multiframe lasts K·F/4 clocks.

The generator watches its own pulse. A rising edge of the pulse restarts the multiframe counter, which puts the counter on the multiframe boundary. Detection runs on every edge, not only on the first one. The first detected edge sets a sticky status flag. Each later edge is checked against the counter. If such an edge arrives while the counter is not on its last count, a sticky misalignment flag is set. A one-cycle re-arm input clears both flags, and the next edge is then handled as a first detection again. The usual way to trigger a misalignment is to reconfigure the block while it is running.

Top module: `sysref_lmfc_top`

## Requirements
- R1: While `rst_i` is high, synchronously and for every cycle after the first clock edge, `sysref_o`, `first_seen_o` and `misalign_o` are all low.
- R2: K (`frames_per_mf_i`) and F (`octets_per_frame_i`) are unsigned binary numbers, and K·F must be divisible by 4. The multiframe length is L = K·F/4 link clocks. Cycle 0 is the first cycle whose closing edge samples `rst_i` low. Until the first SYSREF edge, `mf_boundary_o` is high for one cycle in every cycle c with c mod L = 0, and low in all other cycles.
- R3: The multiplier M (`period_mult_i`, unsigned, with 0 taken as 1) sets the period P = L·M, and P is never less than 2. `sysref_o` is high for exactly one cycle, first in cycle P and then every P cycles while the configuration does not change.
- R4: A SYSREF rising edge in cycle c restarts the multiframe counter. `mf_boundary_o` is then high in cycle c+1 and every L cycles after that, until the next edge.
- R5: `first_seen_o` is low until the first SYSREF edge. It goes high in the cycle after that edge and stays high until re-arm or reset.
- R6: A high `rearm_i` in cycle c makes `first_seen_o` and `misalign_o` low in cycle c+1, unless an edge also occurs in cycle c. The next edge then sets `first_seen_o` and is not checked for alignment. If an edge and re-arm occur in the same cycle, the edge is handled as a first detection.
- R7: Suppose an edge arrives while `first_seen_o` is high and the multiframe counter is not on its last count, so the edge is not in the cycle just before a boundary. Then `misalign_o` goes high in the next cycle and stays high until re-arm or reset. When M is lowered below the current period count, the period counter wraps at the next clock edge, and this can produce such an edge.
- R8: With a steady configuration, every edge after the first lands on the boundary, and `misalign_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link clock |
| rst_i | input | 1 | Synchronous reset, active high |
| frames_per_mf_i | input | K_W (6) | Frames per multiframe, K |
| octets_per_frame_i | input | F_W (5) | Octets per frame, F |
| period_mult_i | input | MULT_W (4) | SYSREF period in multiframes, M (0 means 1) |
| rearm_i | input | 1 | One-cycle clear of both status flags; re-arms first detection |
| sysref_o | output | 1 | One-cycle periodic SYSREF pulse |
| mf_boundary_o | output | 1 | One-cycle strobe at each local multiframe boundary |
| first_seen_o | output | 1 | Sticky flag: a SYSREF edge has been detected since reset or re-arm |
| misalign_o | output | 1 | Sticky flag: a later SYSREF edge arrived off the multiframe boundary |

## Verification
The bench covers the following corner cases. Each entry names the defect that the case would expose.

- The first pulse after reset does not line up with the free-running multiframe counter. A design that checked this first edge would raise a false misalignment.
- The counter must restart on the cycle after each pulse. A design that restarted one cycle late, or that did not restart at all, would put the boundary strobe in the wrong cycles.
- The multiplier is lowered in mid-run while the period count is above the new limit. A design that compared with equality would run on for thousands of cycles without a pulse. A design that missed the off-boundary edge would leave `misalign_o` low.
- Re-arm is exercised between pulses. A design that did not treat the next edge as a first detection would fail to clear the flags, or would set them again too early.

// File: rtl/sysref_lmfc_pkg.sv
package sysref_lmfc_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   // Octets carried per link clock by the datapath.
   localparam int unsigned OCTETS_PER_CLK_DEF = 4;

   // Zero means "one" for count-type configuration fields.
   function automatic logic [15:0] at_least_one(input logic [15:0] v);
      return (v == 16'd0) ? 16'd1 : v;
   endfunction
endpackage

// File: rtl/sysref_mf_len.sv
module sysref_mf_len #(
   parameter int unsigned K_W         = 6,
   parameter int unsigned F_W         = 5,
   parameter int unsigned OCT_PER_CLK = 4,
   localparam int unsigned LEN_W      = K_W + F_W
) (
   input  logic [K_W-1:0]   frames_i,
   input  logic [F_W-1:0]   octets_i,
   output logic [LEN_W-1:0] len_last_o
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned SH     = (OCT_PER_CLK > 1) ? $clog2(OCT_PER_CLK) : 0;
   localparam bit          IS_POW = ((1 << SH) == OCT_PER_CLK);

   logic [LEN_W-1:0] prod;
   logic [LEN_W-1:0] len;

   assign prod = {{F_W{1'b0}}, frames_i} * {{K_W{1'b0}}, octets_i};

   // Power-of-two word width divides by a shift; anything else needs a divider.
   generate
      if (IS_POW) begin : g_shift
         assign len = prod >> SH;
      end else begin : g_div
         assign len = prod / LEN_W'(OCT_PER_CLK);
      end
   endgenerate

   assign len_last_o = (len == '0) ? '0 : len - LEN_W'(1);
endmodule

// File: rtl/sysref_period_gen.sv
module sysref_period_gen #(
   parameter int unsigned LEN_W  = 11,
   parameter int unsigned MULT_W = 4,
   localparam int unsigned PER_W = LEN_W + MULT_W
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [LEN_W-1:0]  len_last_i,
   input  logic [MULT_W-1:0] mult_i,
   output logic              pulse_o
);
   timeunit 1ns;
   timeprecision 1ps;
   import sysref_lmfc_pkg::*;

   logic [LEN_W-1:0]  len;
   logic [MULT_W-1:0] mult_eff;
   logic [PER_W-1:0]  period;
   logic [PER_W-1:0]  per_last;
   logic [PER_W-1:0]  pcnt;
   logic              wrap;
   logic [15:0]       mult_wide;

   assign mult_wide = at_least_one(16'(mult_i));
   assign mult_eff  = mult_wide[MULT_W-1:0];
   assign len       = len_last_i + LEN_W'(1);
   assign period    = {{MULT_W{1'b0}}, len} * {{LEN_W{1'b0}}, mult_eff};
   assign per_last  = (period < PER_W'(2)) ? PER_W'(1) : period - PER_W'(1);
   // ">=" so that shrinking the period at run time cannot strand the count.
   assign wrap      = (pcnt >= per_last);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         pcnt    <= '0;
         pulse_o <= 1'b0;
      end else begin
         pcnt    <= wrap ? '0 : pcnt + PER_W'(1);
         pulse_o <= wrap;
      end
   end
endmodule

// File: rtl/sysref_edge_det.sv
module sysref_edge_det (
   input  logic clk_i,
   input  logic rst_i,
   input  logic sig_i,
   output logic rise_o
);
   timeunit 1ns;
   timeprecision 1ps;

   logic prev_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) prev_q <= 1'b0;
      else       prev_q <= sig_i;
   end

   assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/sysref_lmfc_track.sv
module sysref_lmfc_track #(
   parameter int unsigned LEN_W = 11
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [LEN_W-1:0] len_last_i,
   input  logic             edge_i,
   input  logic             rearm_i,
   output logic             boundary_o,
   output logic             first_seen_o,
   output logic             misalign_o
);
   timeunit 1ns;
   timeprecision 1ps;

   logic [LEN_W-1:0] mf_cnt;
   logic             on_last;

   assign on_last = (mf_cnt == len_last_i);

   always_ff @(posedge clk_i) begin
      if (rst_i)                    mf_cnt <= '0;
      else if (edge_i)              mf_cnt <= '0;
      else if (mf_cnt >= len_last_i) mf_cnt <= '0;
      else                          mf_cnt <= mf_cnt + LEN_W'(1);
   end

   // An edge outranks re-arm: it is then treated as a fresh first detection.
   always_ff @(posedge clk_i) begin
      if (rst_i)        first_seen_o <= 1'b0;
      else if (edge_i)  first_seen_o <= 1'b1;
      else if (rearm_i) first_seen_o <= 1'b0;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i)                                     misalign_o <= 1'b0;
      else if (rearm_i)                              misalign_o <= 1'b0;
      else if (edge_i && first_seen_o && !on_last)   misalign_o <= 1'b1;
   end

   assign boundary_o = (mf_cnt == '0);
endmodule

// File: rtl/sysref_lmfc_top.sv
module sysref_lmfc_top #(
   parameter int unsigned K_W         = 6,
   parameter int unsigned F_W         = 5,
   parameter int unsigned MULT_W      = 4,
   parameter int unsigned OCT_PER_CLK = sysref_lmfc_pkg::OCTETS_PER_CLK_DEF
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [K_W-1:0]    frames_per_mf_i,
   input  logic [F_W-1:0]    octets_per_frame_i,
   input  logic [MULT_W-1:0] period_mult_i,
   input  logic              rearm_i,
   output logic              sysref_o,
   output logic              mf_boundary_o,
   output logic              first_seen_o,
   output logic              misalign_o
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned LEN_W = K_W + F_W;

   generate
      if (K_W < 1 || F_W < 1 || MULT_W < 1) begin : g_bad_width
         $error("sysref_lmfc_top: field widths must be at least one bit");
      end
      if (MULT_W > 16) begin : g_bad_mult
         $error("sysref_lmfc_top: multiplier field wider than 16 bits");
      end
      if (OCT_PER_CLK < 1) begin : g_bad_word
         $error("sysref_lmfc_top: octets per clock must be positive");
      end
   endgenerate

   logic [LEN_W-1:0] len_last;
   logic             rise;

   sysref_mf_len #(.K_W(K_W), .F_W(F_W), .OCT_PER_CLK(OCT_PER_CLK)) len_i (
      .frames_i   (frames_per_mf_i),
      .octets_i   (octets_per_frame_i),
      .len_last_o (len_last)
   );

   sysref_period_gen #(.LEN_W(LEN_W), .MULT_W(MULT_W)) gen_i (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .len_last_i (len_last),
      .mult_i     (period_mult_i),
      .pulse_o    (sysref_o)
   );

   sysref_edge_det edge_i (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .sig_i  (sysref_o),
      .rise_o (rise)
   );

   sysref_lmfc_track #(.LEN_W(LEN_W)) trk_i (
      .clk_i        (clk_i),
      .rst_i        (rst_i),
      .len_last_i   (len_last),
      .edge_i       (rise),
      .rearm_i      (rearm_i),
      .boundary_o   (mf_boundary_o),
      .first_seen_o (first_seen_o),
      .misalign_o   (misalign_o)
   );
endmodule

// File: rtl/sysref_lmfc_chk.sv
module sysref_lmfc_chk (
   input logic clk_i,
   input logic rst_i,
   input logic rearm_i,
   input logic sysref_o,
   input logic mf_boundary_o,
   input logic first_seen_o,
   input logic misalign_o
);
   timeunit 1ns;
   timeprecision 1ps;

   assert_reset_quiet_R1: assert property (@(posedge clk_i)
      rst_i |=> (!sysref_o && !first_seen_o && !misalign_o));

   assert_pulse_one_cycle_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      sysref_o |=> !sysref_o);

   assert_boundary_after_edge_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      sysref_o |=> mf_boundary_o);

   assert_first_seen_set_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      sysref_o |=> first_seen_o);

   assert_first_seen_sticky_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      (first_seen_o && !rearm_i) |=> first_seen_o);

   assert_rearm_clears_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      (rearm_i && !sysref_o) |=> (!first_seen_o && !misalign_o));

   assert_misalign_sticky_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      (misalign_o && !rearm_i) |=> misalign_o);

   assert_misalign_cause_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(misalign_o) |-> ($past(sysref_o) && $past(first_seen_o)));
endmodule

bind sysref_lmfc_top sysref_lmfc_chk chk_i (
   .clk_i         (clk_i),
   .rst_i         (rst_i),
   .rearm_i       (rearm_i),
   .sysref_o      (sysref_o),
   .mf_boundary_o (mf_boundary_o),
   .first_seen_o  (first_seen_o),
   .misalign_o    (misalign_o)
);

// File: tb/sysref_lmfc_top_tb_top.sv
module sysref_lmfc_top_tb_top;
   timeunit 1ns;
   timeprecision 1ps;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [5:0] k_cfg = 6'd4;
   logic [4:0] f_cfg = 5'd4;
   logic [3:0] m_cfg = 4'd3;
   logic       rearm = 1'b0;
   logic       sysref_o, mf_boundary_o, first_seen_o, misalign_o;

   always #2 clk = ~clk;  // 250 MHz

   sysref_lmfc_top dut_i (
      .clk_i              (clk),
      .rst_i              (rst),
      .frames_per_mf_i    (k_cfg),
      .octets_per_frame_i (f_cfg),
      .period_mult_i      (m_cfg),
      .rearm_i            (rearm),
      .sysref_o           (sysref_o),
      .mf_boundary_o      (mf_boundary_o),
      .first_seen_o       (first_seen_o),
      .misalign_o         (misalign_o)
   );

   int unsigned cyc;
   always @(posedge clk) begin
      if (rst) cyc <= 0;
      else     cyc <= cyc + 1;
   end

   int          n_chk = 0;
   int          n_err = 0;
   bit          done = 1'b0;
   bit          mon_on = 1'b0;
   int unsigned ph = 0;
   int unsigned cur_len = 1;
   int unsigned exp_q[$];

   function automatic void chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
      end
   endfunction

   // Monitor: pops expected pulse cycles and tracks the expected boundary phase.
   always @(negedge clk) begin
      #1;
      if (mon_on && !done) begin
         chk("R2/R4 boundary strobe", int'(mf_boundary_o), int'(ph == 0));
         if (exp_q.size() > 0 && exp_q[0] < cyc) begin
            chk("R3 missed pulse", int'(cyc), int'(exp_q[0]));
            void'(exp_q.pop_front());
         end
         if (sysref_o) begin
            if (exp_q.size() == 0) chk("R3 unexpected pulse", 1, 0);
            else                   chk("R3 pulse cycle", int'(cyc), int'(exp_q.pop_front()));
         end
         if (sysref_o)                ph = 0;
         else if (ph + 1 >= cur_len)  ph = 0;
         else                         ph = ph + 1;
      end
   end

   task automatic step();
      @(negedge clk);
   endtask

   task automatic to_cyc(input int unsigned n);
      while (cyc < n) step();
   endtask

   task automatic do_reset(input int unsigned k, input int unsigned f, input int unsigned m);
      mon_on = 1'b0;
      rst    = 1'b1;
      k_cfg  = 6'(k);
      f_cfg  = 5'(f);
      m_cfg  = 4'(m);
      repeat (3) step();
      chk("R1 sysref in reset", int'(sysref_o), 0);
      chk("R1 first_seen in reset", int'(first_seen_o), 0);
      chk("R1 misalign in reset", int'(misalign_o), 0);
      cur_len = (k * f) / 4;
      exp_q.delete();
      ph     = 0;
      rst    = 1'b0;
      mon_on = 1'b1;
   endtask

   initial begin
      // Run A: K=10, F=2 -> L=5, M=2 -> P=10.
      do_reset(10, 2, 2);
      exp_q.push_back(10); exp_q.push_back(20); exp_q.push_back(30);
      to_cyc(10);
      chk("R5 first_seen before edge", int'(first_seen_o), 0);
      to_cyc(11);
      chk("R5 first_seen after first edge", int'(first_seen_o), 1);
      chk("R8 first edge unchecked", int'(misalign_o), 0);
      to_cyc(21);
      chk("R8 aligned second edge", int'(misalign_o), 0);
      to_cyc(32);

      // Run B: K=4, F=4 -> L=4, M=3 -> P=12.
      do_reset(4, 4, 3);
      exp_q.push_back(12); exp_q.push_back(24); exp_q.push_back(36); exp_q.push_back(48);
      to_cyc(12);
      chk("R5 first_seen before edge", int'(first_seen_o), 0);
      to_cyc(13);
      chk("R5 first_seen after edge", int'(first_seen_o), 1);
      chk("R8 first edge off phase", int'(misalign_o), 0);
      to_cyc(25);
      chk("R8 steady edge aligned", int'(misalign_o), 0);
      to_cyc(30);
      rearm = 1'b1;
      step();
      rearm = 1'b0;
      chk("R6 rearm clears first_seen", int'(first_seen_o), 0);
      to_cyc(37);
      chk("R6 edge after rearm sets first_seen", int'(first_seen_o), 1);
      chk("R6 edge after rearm not flagged", int'(misalign_o), 0);

      // Shrink the period while the count is 5: wrap at once, edge off boundary.
      to_cyc(53);
      m_cfg = 4'd1;
      exp_q.delete();
      exp_q.push_back(54); exp_q.push_back(58); exp_q.push_back(62);
      exp_q.push_back(66); exp_q.push_back(70);
      to_cyc(54);
      chk("R7 misalign before flag cycle", int'(misalign_o), 0);
      to_cyc(55);
      chk("R7 misalign after off-boundary edge", int'(misalign_o), 1);
      to_cyc(62);
      chk("R7 misalign sticky", int'(misalign_o), 1);
      to_cyc(64);
      rearm = 1'b1;
      step();
      rearm = 1'b0;
      chk("R6 rearm clears misalign", int'(misalign_o), 0);
      chk("R6 rearm clears first_seen", int'(first_seen_o), 0);
      to_cyc(71);
      chk("R6 redetect after rearm", int'(first_seen_o), 1);
      chk("R8 aligned after rearm", int'(misalign_o), 0);
      chk("R3 all pulses seen", exp_q.size(), 0);

      mon_on = 1'b0;
      done   = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired at cycle %0d: actual running expected done", cyc);
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule